// File: doc/BRIEF.md
# Conversion Result Byte Register Bank

This block holds the newest 10-bit converter result and exposes it to an 8-bit host as a high byte and a low byte. A static input picks the alignment of the value inside the 16-bit pair. The first byte of a pair that the host reads depends on that alignment: the high byte in left alignment and the low byte in right alignment. That first read captures the matching byte into a shadow copy. The second read of the pair then returns that copy, so both bytes come from the same conversion even when a newer result arrives between the two reads.

When buffered mode is on, each result is also written into a ring of slots in turn, one slot per input channel. Each slot is readable as its own byte pair and follows the same ordering rule. A slot counts as unread from the time it is written until both of its bytes have been read in the required order. A sticky overrun flag is raised when a result lands on a slot that is still unread. Conversion control sits outside the block, which only sees a one-cycle result-valid pulse with the data.

Address map: 0 = main pair high byte, 1 = main pair low byte, 2 = status (bit 0 is the overrun flag; writing a 1 to bit 0 clears it). Slot i has its high byte at SLOT_BASE+2i and its low byte at SLOT_BASE+2i+1, with SLOT_BASE = 16.

Top module: `conv_result_bank`

## Requirements
- R1: After reset every mapped byte (main pair, every slot pair and status) reads 0, and the overrun flag is 0.
- R2: With align_left=1 the high byte holds result bits 9..2, and the low byte holds bits 1..0 in its bits 7..6 with bits 5..0 reading 0. The main pair always shows the latest result presented with res_valid.
- R3: With align_left=0 the high byte holds result bits 9..8 in its bits 1..0 with bits 7..2 reading 0, and the low byte holds bits 7..0.
- R4: Reading the first byte of a pair (the low byte when align_left=0, the high byte when align_left=1) captures the other byte of the same pair. The next read of that other byte returns the captured value, even if a new result arrived in between. That read releases the capture.
- R5: Reading the second byte of a pair with no capture held for that pair returns the live value and leaves no capture in place.
- R6: With buf_mode=1, successive results go into slots 0,1,...,SLOTS-1 and then wrap to slot 0.
- R7: With buf_mode=0, results update only the main pair. The slots and the write position stay unchanged.
- R8: The overrun flag is set in the cycle after a result overwrites a slot that has not been read in order since it was last written. Results that land only on read slots leave the flag at 0.
- R9: The overrun flag is sticky. A status write with wdata bit 0 = 1 clears it, and a write with bit 0 = 0 has no effect. A new overrun in the same cycle as a clear leaves the flag set.
- R10: If a read completes a slot pair in the same cycle as a result overwrites that slot, the read returns the old captured byte, no overrun is flagged, and the slot then holds the new result.
- R11: The status byte returns the overrun flag in bit 0 and zeros in bits 7..1. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | One-cycle pulse: res_data holds a new result |
| res_data | input | 10 | Conversion result |
| align_left | input | 1 | 1 = left alignment, 0 = right alignment |
| buf_mode | input | 1 | 1 = also store results in the slot ring |
| rd_en | input | 1 | Host byte read strobe |
| wr_en | input | 1 | Host byte write strobe |
| addr | input | ADDR_W | Host byte address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, valid in the cycle of rd_en |
| ovr_flag | output | 1 | Sticky overrun flag |

## Verification
Two pairs of events can fall in the same cycle. The first is an in-order read that completes a slot pair while a new result overwrites that slot. The bench drives the second-byte read and the result pulse in one cycle. It expects the old byte on rdata, a clear overrun flag, and then the new value in the slot. The second is an overrun that coincides with a host clear. The bench drives a pulse onto an unread slot together with a status write of 1 and expects the flag to stay set. Behind this, a full sweep of all 1024 result values in both alignments checks the byte formats against arithmetic shifts and masks.

// File: rtl/conv_res_pkg.sv
package conv_res_pkg;
   localparam int RES_W  = 10;
   localparam int BYTE_W = 8;

   typedef logic [RES_W-1:0]  res_t;
   typedef logic [BYTE_W-1:0] byte_t;

   // high byte of a result as laid out for the selected alignment
   function automatic byte_t fmt_hi(res_t v, logic left);
      return left ? v[9:2] : {6'b0, v[9:8]};
   endfunction

   // low byte of a result as laid out for the selected alignment
   function automatic byte_t fmt_lo(res_t v, logic left);
      return left ? {v[1:0], 6'b0} : v[7:0];
   endfunction
endpackage

// File: rtl/conv_res_ring.sv
module conv_res_ring
   import conv_res_pkg::*;
#(
   parameter int SLOTS = 8,
   localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        push,
   input  logic [RES_W-1:0]            push_data,
   input  logic                        done_v,
   input  logic [IDX_W-1:0]            done_idx,
   input  logic                        ovr_clr,
   output logic [SLOTS-1:0][RES_W-1:0] slot_q,
   output logic [IDX_W-1:0]            wptr,
   output logic                        ovr_q
);
   logic [SLOTS-1:0] pend;
   logic [SLOTS-1:0] we;
   logic [SLOTS-1:0] rel;
   logic             hit_unread;

   generate
      for (genvar g = 0; g < SLOTS; g++) begin : g_slot_dec
         assign we[g]  = push   && (wptr     == IDX_W'(g));
         assign rel[g] = done_v && (done_idx == IDX_W'(g));
      end
   endgenerate

   // a result lands on a slot whose last value was never read in order
   assign hit_unread = push && pend[wptr] && !(done_v && (done_idx == wptr));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_q <= '0;
         pend   <= '0;
      end else begin
         for (int i = 0; i < SLOTS; i++) begin
            if (we[i]) begin
               slot_q[i] <= push_data;
               pend[i]   <= 1'b1;
            end else if (rel[i]) begin
               pend[i]   <= 1'b0;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         wptr <= '0;
      else if (push)
         wptr <= (wptr == IDX_W'(SLOTS-1)) ? '0 : wptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         ovr_q <= 1'b0;
      else if (hit_unread)
         ovr_q <= 1'b1;
      else if (ovr_clr)
         ovr_q <= 1'b0;
   end
endmodule

// File: rtl/conv_res_latch.sv
module conv_res_latch
   import conv_res_pkg::*;
#(
   parameter int PAIR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap,
   input  logic [PAIR_W-1:0] cap_pair,
   input  logic [BYTE_W-1:0] cap_byte,
   input  logic              rel,
   input  logic [PAIR_W-1:0] q_pair,
   output logic              hit,
   output logic              lat_v,
   output logic [PAIR_W-1:0] lat_pair,
   output logic [BYTE_W-1:0] lat_byte
);
   assign hit = lat_v && (lat_pair == q_pair);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lat_v    <= 1'b0;
         lat_pair <= '0;
         lat_byte <= '0;
      end else if (cap) begin
         lat_v    <= 1'b1;
         lat_pair <= cap_pair;
         lat_byte <= cap_byte;
      end else if (rel && hit) begin
         lat_v    <= 1'b0;
      end
   end
endmodule

// File: rtl/conv_result_bank.sv
module conv_result_bank
   import conv_res_pkg::*;
#(
   parameter int SLOTS     = 8,
   parameter int ADDR_W    = 6,
   parameter int SLOT_BASE = 16,
   localparam int IDX_W    = (SLOTS > 1) ? $clog2(SLOTS) : 1,
   localparam int PAIR_W   = $clog2(SLOTS + 1),
   localparam int STAT_A   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              res_valid,
   input  logic [RES_W-1:0]  res_data,
   input  logic              align_left,
   input  logic              buf_mode,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] rdata,
   output logic              ovr_flag
);
   generate
      if (SLOTS < 1 || SLOTS > 16) begin : g_bad_slots
         $error("SLOTS must be 1..16");
      end
      if (SLOT_BASE < 4 || (SLOT_BASE % 2) != 0) begin : g_bad_base
         $error("SLOT_BASE must be even and above the status byte");
      end
      if ((1 << ADDR_W) < SLOT_BASE + 2*SLOTS) begin : g_bad_addr
         $error("ADDR_W too narrow for the slot window");
      end
   endgenerate

   res_t                        main_q;
   logic [SLOTS-1:0][RES_W-1:0] slot_q;
   logic [IDX_W-1:0]            wptr;
   logic                        is_main, is_stat, is_slot, is_pair;
   logic [IDX_W-1:0]            slot_idx;
   logic [PAIR_W-1:0]           pair;
   res_t                        src;
   logic                        want_hi, first;
   byte_t                       live_byte, partner;
   logic                        rd_first, rd_second;
   logic                        hit, lat_v;
   logic [PAIR_W-1:0]           lat_pair;
   byte_t                       lat_byte;
   logic                        done_v, ovr_clr;

   // address decode
   always_comb begin
      int a;
      a        = int'(addr);
      is_main  = (a < 2);
      is_stat  = (a == STAT_A);
      is_slot  = (a >= SLOT_BASE) && (a < SLOT_BASE + 2*SLOTS);
      is_pair  = is_main || is_slot;
      slot_idx = is_slot ? IDX_W'((a - SLOT_BASE) >> 1) : '0;
      pair     = is_main ? '0 : PAIR_W'(slot_idx) + 1'b1;
   end

   assign src       = is_main ? main_q : slot_q[slot_idx];
   assign want_hi   = !addr[0];
   assign first     = (want_hi == align_left);
   assign live_byte = want_hi ? fmt_hi(src, align_left) : fmt_lo(src, align_left);
   assign partner   = want_hi ? fmt_lo(src, align_left) : fmt_hi(src, align_left);
   assign rd_first  = rd_en && is_pair && first;
   assign rd_second = rd_en && is_pair && !first;
   assign done_v    = rd_second && hit && !is_main;
   assign ovr_clr   = wr_en && is_stat && wdata[0];

   always_ff @(posedge clk) begin
      if (!rst_n)
         main_q <= '0;
      else if (res_valid)
         main_q <= res_data;
   end

   conv_res_latch #(.PAIR_W(PAIR_W)) u_lat (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap      (rd_first),
      .cap_pair (pair),
      .cap_byte (partner),
      .rel      (rd_second),
      .q_pair   (pair),
      .hit      (hit),
      .lat_v    (lat_v),
      .lat_pair (lat_pair),
      .lat_byte (lat_byte)
   );

   conv_res_ring #(.SLOTS(SLOTS)) u_ring (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (res_valid && buf_mode),
      .push_data (res_data),
      .done_v    (done_v),
      .done_idx  (slot_idx),
      .ovr_clr   (ovr_clr),
      .slot_q    (slot_q),
      .wptr      (wptr),
      .ovr_q     (ovr_flag)
   );

   always_comb begin
      if (is_stat)
         rdata = {7'b0, ovr_flag};
      else if (is_pair)
         rdata = (!first && hit) ? lat_byte : live_byte;
      else
         rdata = '0;
   end
endmodule

// File: rtl/conv_result_chk.sv
module conv_result_chk
   import conv_res_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int PAIR_W = 4,
   parameter int IDX_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              res_valid,
   input logic [RES_W-1:0]  res_data,
   input logic              align_left,
   input logic              buf_mode,
   input logic              rd_en,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [BYTE_W-1:0] wdata,
   input logic [BYTE_W-1:0] rdata,
   input logic              ovr_flag,
   input logic [RES_W-1:0]  main_q,
   input logic              lat_v,
   input logic [PAIR_W-1:0] lat_pair,
   input logic [IDX_W-1:0]  wptr
);
   logic main_held;
   assign main_held = lat_v && (lat_pair == '0);

   AST_MAIN_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> (main_q == $past(res_data))); // R2

   AST_LEFT_LO_PAD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && align_left && addr == ADDR_W'(1) && !main_held) |-> (rdata[5:0] == 6'b0)); // R2

   AST_RIGHT_HI_PAD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !align_left && addr == ADDR_W'(0) && !main_held) |-> (rdata[7:2] == 6'b0)); // R3

   AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (lat_v && !rd_en) |=> (lat_v && $stable(lat_pair))); // R4

   AST_IDLE_WPTR: assert property (@(posedge clk) disable iff (!rst_n)
      !(res_valid && buf_mode) |=> $stable(wptr)); // R7

   AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_flag) |-> $past(res_valid && buf_mode)); // R8

   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_flag && !(wr_en && addr == ADDR_W'(2) && wdata[0])) |=> ovr_flag); // R9

   AST_STATUS_PAD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == ADDR_W'(2)) |-> (rdata[7:1] == 7'b0)); // R11
endmodule

bind conv_result_bank conv_result_chk #(
   .ADDR_W (ADDR_W),
   .PAIR_W (PAIR_W),
   .IDX_W  (IDX_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .res_valid  (res_valid),
   .res_data   (res_data),
   .align_left (align_left),
   .buf_mode   (buf_mode),
   .rd_en      (rd_en),
   .wr_en      (wr_en),
   .addr       (addr),
   .wdata      (wdata),
   .rdata      (rdata),
   .ovr_flag   (ovr_flag),
   .main_q     (main_q),
   .lat_v      (lat_v),
   .lat_pair   (lat_pair),
   .wptr       (wptr)
);

// File: tb/tb_conv_result_bank.sv
module tb_conv_result_bank;
   localparam int SL = 4;
   localparam int AW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          res_valid = 1'b0;
   logic [9:0]    res_data = '0;
   logic          align_left = 1'b0;
   logic          buf_mode = 1'b0;
   logic          rd_en = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [7:0]    wdata = '0;
   logic [7:0]    rdata;
   logic          ovr_flag;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #5 clk = ~clk;

   conv_result_bank #(.SLOTS(SL), .ADDR_W(AW), .SLOT_BASE(16)) dut (
      .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
      .align_left(align_left), .buf_mode(buf_mode), .rd_en(rd_en), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .ovr_flag(ovr_flag)
   );

   function automatic logic [7:0] ehi(int v, bit left);
      return left ? 8'((v >> 2) & 255) : 8'((v >> 8) & 3);
   endfunction
   function automatic logic [7:0] elo(int v, bit left);
      return left ? 8'((v & 3) << 6) : 8'(v & 255);
   endfunction

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic rd(input int a, output logic [7:0] d);
      rd_en = 1'b1; addr = AW'(a);
      #2 d = rdata;
      @(posedge clk); #1;
      rd_en = 1'b0;
   endtask

   task automatic push(input int v);
      res_valid = 1'b1; res_data = 10'(v);
      @(posedge clk); #1;
      res_valid = 1'b0;
   endtask

   task automatic wr(input int a, input int d);
      wr_en = 1'b1; addr = AW'(a); wdata = 8'(d);
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   // reads a pair in the order the current alignment requires
   task automatic rd_pair(input int hi_a, output logic [7:0] h, output logic [7:0] l);
      if (align_left) begin
         rd(hi_a, h); rd(hi_a + 1, l);
      end else begin
         rd(hi_a + 1, l); rd(hi_a, h);
      end
   endtask

   task automatic chk_pair(string tag, int hi_a, int v);
      logic [7:0] h, l;
      rd_pair(hi_a, h, l);
      chk({tag, " hi"}, h, ehi(v, align_left));
      chk({tag, " lo"}, l, elo(v, align_left));
   endtask

   function automatic int slot_a(int i);
      return 16 + 2*i;
   endfunction

   initial begin
      #2_000_000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog act=running exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      int c[4];
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset contents
      rd(0, d);  chk("R1 main hi", d, 8'h00);
      rd(1, d);  chk("R1 main lo", d, 8'h00);
      rd(2, d);  chk("R1 status", d, 8'h00);
      for (int i = 0; i < SL; i++) begin
         rd(slot_a(i), d);     chk("R1 slot hi", d, 8'h00);
         rd(slot_a(i) + 1, d); chk("R1 slot lo", d, 8'h00);
      end

      // R2 / R3: sweep every result value in both alignments
      for (int al = 0; al < 2; al++) begin
         align_left = al[0];
         for (int v = 0; v < 1024; v++) begin
            push(v);
            chk_pair(al ? "R2" : "R3", 0, v);
         end
      end

      // R4: capture in right alignment survives a new result
      align_left = 1'b0;
      push(10'h2A5);
      rd(1, d); chk("R4 right first", d, 8'hA5);
      push(10'h15A);
      rd(0, d); chk("R4 right captured", d, ehi(10'h2A5, 0));
      // R5: no capture left, second byte is live
      rd(0, d); chk("R5 live after release", d, ehi(10'h15A, 0));
      push(10'h3FF);
      rd(0, d); chk("R5 live no capture", d, ehi(10'h3FF, 0));
      rd(0, d); chk("R5 still live", d, ehi(10'h3FF, 0));
      // R4: left alignment, high byte first
      align_left = 1'b1;
      push(10'h2A5);
      rd(0, d); chk("R4 left first", d, ehi(10'h2A5, 1));
      push(10'h001);
      rd(1, d); chk("R4 left captured", d, elo(10'h2A5, 1));
      rd(1, d); chk("R5 left live", d, elo(10'h001, 1));

      // R6: ring fill in order (right alignment)
      align_left = 1'b0;
      buf_mode = 1'b1;
      c = '{10'h011, 10'h122, 10'h233, 10'h344};
      for (int i = 0; i < SL; i++) push(c[i]);
      for (int i = 0; i < SL; i++) chk_pair("R6 slot", slot_a(i), c[i]);
      rd(2, d); chk("R8 no overrun when read", d, 8'h00);

      // R7: buffered mode off leaves slots alone
      buf_mode = 1'b0;
      push(10'h3C3);
      chk_pair("R7 slot0 kept", slot_a(0), c[0]);
      chk_pair("R7 main updated", 0, 10'h3C3);

      // R6 / R8: wrap and overwrite an unread slot
      buf_mode = 1'b1;
      c = '{10'h055, 10'h166, 10'h277, 10'h388};
      for (int i = 0; i < SL; i++) push(c[i]);
      rd(2, d); chk("R8 clear before wrap", d, 8'h00);
      push(10'h099);
      rd(2, d); chk("R8 overrun set", d, 8'h01);
      chk_pair("R6 wrapped to slot0", slot_a(0), 10'h099);
      for (int i = 1; i < SL; i++) chk_pair("R6 slot", slot_a(i), c[i]);

      // R9: sticky, write 0 ignored, write 1 clears
      wr(2, 0);
      rd(2, d); chk("R9 write0 ignored", d, 8'h01);
      wr(2, 1);
      rd(2, d); chk("R9 cleared", d, 8'h00);
      // fill slots 1,2,3,0 unread, then overwrite slot1 during a clear
      c = '{10'h101, 10'h202, 10'h303, 10'h004};
      for (int i = 0; i < SL; i++) push(c[i]);
      rd(2, d); chk("R9 no overrun yet", d, 8'h00);
      res_valid = 1'b1; res_data = 10'h3AA;
      wr_en = 1'b1; addr = AW'(2); wdata = 8'h01;
      @(posedge clk); #1;
      res_valid = 1'b0; wr_en = 1'b0;
      rd(2, d); chk("R9 set wins over clear", d, 8'h01);
      wr(2, 1);
      rd(2, d); chk("R9 cleared again", d, 8'h00);

      // R10: slot2 holds 0x202 unread; finish its read as 0x1EE lands on it
      rd(slot_a(2) + 1, d); chk("R10 first byte", d, elo(10'h202, 0));
      rd_en = 1'b1; addr = AW'(slot_a(2));
      res_valid = 1'b1; res_data = 10'h1EE;
      #2 d = rdata;
      @(posedge clk); #1;
      rd_en = 1'b0; res_valid = 1'b0;
      chk("R10 old captured byte", d, ehi(10'h202, 0));
      rd(2, d); chk("R10 no overrun", d, 8'h00);
      chk_pair("R10 new slot value", slot_a(2), 10'h1EE);

      // R11: status padding and unmapped reads
      rd(5, d);  chk("R11 unmapped 5", d, 8'h00);
      rd(15, d); chk("R11 unmapped 15", d, 8'h00);
      rd(slot_a(SL), d); chk("R11 past slots", d, 8'h00);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule